// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts activity for a processor core. Two programmable counters each pick one line out of a vector of single-cycle event pulses. A third counter counts clock cycles. All three share one global run bit. Each counter can be written to any value and read back through a small register bus. A counter that passes its top value sets its own sticky overflow flag. The flags, masked by per-counter interrupt enables, drive one registered interrupt line.

The programmable counters have no enable bits of their own. Software stops one by pointing its select field at event code 0x20. That is an external-output line which stays low while export is off. Configuration, reset strobes, flags and both select fields all live in one control word. A handler therefore reads the control word, finds the set flags, and writes the word back to clear them.

Top module: `pmon3`

## Requirements
- R1: While control bit 0 (global run) is 0, none of the three counters changes except through a bus write or a reset bit.
- R2: Event select for counter 0 sits in control bits 27:20 and for counter 1 in bits 19:12. While running, a programmable counter adds one at each clock edge where `evt_in[select]` is 1. A new select value applies from the cycle after the write.
- R3: A counter whose select is 0x20 stays frozen while `evt_in[32]` is low, whatever the other event lines do.
- R4: Writing control bit 1 zeroes both programmable counters at that edge. Writing bit 2 zeroes the cycle counter and its prescaler. Neither touches the other group, and both bits always read as 0.
- R5: Counters are 32 bits wide and go from 0xFFFFFFFF to 0 on the next increment. Any written value, zero included, reads back unchanged. A bus write to a counter takes priority over an increment in the same cycle.
- R6: Control bits 8, 9 and 10 are the overflow flags of counter 0, counter 1 and the cycle counter. Each is set at the edge where its counter passes from 0xFFFFFFFF to 0, and stays set until software clears it.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as the clearing write leaves the flag set.
- R8: `irq` is the registered OR, over the three counters, of the flag AND its interrupt enable. The enables are control bit 4 (counter 0), bit 5 (counter 1) and bit 6 (cycle counter). `irq` rises one edge after the flag and enable are both set.
- R9: The cycle counter adds one at each running edge while control bit 3 is 0. While bit 3 is 1 it adds one once every 64 running edges, counted from the last prescaler reset.
- R10: `bus_addr` selects the register: 0 is the control word, 1 is counter 0, 2 is counter 1 and 3 is the cycle counter. After reset every register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` (combinational) |
| evt_in | input | 256 | Event pulse vector, indexed by event code |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The sharpest collision is a counter wrapping in the very cycle that software writes 1 to that counter's overflow flag. The bench first parks counter 0 at 0xFFFFFFFF with the event low. In a single cycle it then raises the selected event and issues the clearing control write. It expects the counter to read 0 and the flag to still read 1. A second overlap is a run-bit clearing write meeting a last cycle tick. The bench expects the cycle counter to include that final edge.

// File: rtl/pmon_pkg.sv
// Package: shared widths, control-word bit positions and register addresses.
// Assumes a 32-bit register bus; the counters use the full bus width.
package pmon_pkg;
    localparam int BUS_W      = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_EVT    = 1 << SEL_W;
    localparam int PRESC_W    = 6;

    localparam int B_RUN      = 0;
    localparam int B_CLR_PRG  = 1;
    localparam int B_CLR_CYC  = 2;
    localparam int B_DIV      = 3;
    localparam int B_IEN_LO   = 4;   // 4: ctr0, 5: ctr1, 6: cycle
    localparam int B_OVF_LO   = 8;   // 8: ctr0, 9: ctr1, 10: cycle
    localparam int B_SEL1_LO  = 12;
    localparam int B_SEL0_LO  = 20;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CTR0 = 2'd1,
        RA_CTR1 = 2'd2,
        RA_CYC  = 2'd3
    } pmon_addr_e;
endpackage

// File: rtl/pmon_evt_ctr.sv
// Programmable event counter. Selects one event line by code and counts it
// while the global run bit is set. Assumes clr and wr never coincide (they
// come from different bus addresses). Flags a wrap through ovf.
module pmon_evt_ctr #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 8,
    localparam int NEVT = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [NEVT-1:0]  evt,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic inc;

    // Increment request: running and the selected event pulsed.
    always_comb begin
        inc = run && evt[sel];
        ovf = inc && (cnt == {CNT_W{1'b1}}) && !wr && !clr;
    end

    // Counter register: reset strobe, then bus write, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (wr)     cnt <= wdata;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr && !clr) |=> $stable(cnt)); // R1
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (cnt == $past(wdata))); // R5
endmodule

// File: rtl/pmon_cyc_ctr.sv
// Cycle counter with optional divide-by-2^PRESC_W prescaler. Counts clock
// edges while running. Assumes clr and wr never coincide. Flags a wrap.
module pmon_cyc_ctr #(
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [PRESC_W-1:0] presc;
    logic               tick;

    // Tick every running edge, or once per prescaler period when dividing.
    always_comb begin
        tick = run && (!div || (presc == {PRESC_W{1'b1}}));
        ovf  = tick && (cnt == {CNT_W{1'b1}}) && !wr && !clr;
    end

    // Prescaler: advances only while running in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     presc <= '0;
        else if (run && div)   presc <= presc + 1'b1;
    end

    // Counter register: reset strobe, then bus write, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (wr)     cnt <= wdata;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div && (presc != {PRESC_W{1'b1}}) && !wr && !clr) |=> $stable(cnt)); // R9
    AST_CYC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && presc == '0)); // R4
endmodule

// File: rtl/pmon_ctrl.sv
// Control word: run, divider, interrupt enables, event selects, sticky
// overflow flags (write-one-to-clear, set wins) and the registered interrupt.
// Reset strobes are combinational pulses decoded from the write itself.
module pmon_ctrl
    import pmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [2:0]       ovf_set,
    output logic             run,
    output logic             div,
    output logic             clr_prg,
    output logic             clr_cyc,
    output logic [SEL_W-1:0] sel0,
    output logic [SEL_W-1:0] sel1,
    output logic [BUS_W-1:0] rd,
    output logic             irq
);
    logic [2:0] ien_q;
    logic [2:0] flag_q;
    logic [2:0] flag_clr;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[BUS_W-1:B_SEL0_LO+SEL_W], wdata[B_OVF_LO+3], wdata[B_IEN_LO+3]};

    // Reset strobes and flag-clear mask decoded from the current write.
    always_comb begin
        clr_prg  = wr && wdata[B_CLR_PRG];
        clr_cyc  = wr && wdata[B_CLR_CYC];
        flag_clr = wr ? wdata[B_OVF_LO +: 3] : 3'b000;
    end

    // Configuration fields: loaded on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; div <= 1'b0; ien_q <= '0; sel0 <= '0; sel1 <= '0;
        end else if (wr) begin
            run   <= wdata[B_RUN];
            div   <= wdata[B_DIV];
            ien_q <= wdata[B_IEN_LO +: 3];
            sel0  <= wdata[B_SEL0_LO +: SEL_W];
            sel1  <= wdata[B_SEL1_LO +: SEL_W];
        end
    end

    // Sticky flags: a wrap sets, a one written clears, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | ovf_set;
    end

    // Interrupt register: any flagged counter with its enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_q & ien_q);
    end

    // Readback assembly; reset strobes read as zero.
    always_comb begin
        rd                    = '0;
        rd[B_RUN]             = run;
        rd[B_DIV]             = div;
        rd[B_IEN_LO +: 3]     = ien_q;
        rd[B_OVF_LO +: 3]     = flag_q;
        rd[B_SEL1_LO +: SEL_W] = sel1;
        rd[B_SEL0_LO +: SEL_W] = sel0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set != 3'b000) |=> ((flag_q & $past(ovf_set)) == $past(ovf_set))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && ovf_set == 3'b000) |=> $stable(flag_q)); // R6
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_OVF_LO +: 3] == 3'b111 && ovf_set == 3'b000) |=> (flag_q == 3'b000)); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 3'b000) |=> !irq); // R8
endmodule

// File: rtl/pmon3.sv
// Top: address decode, two programmable counters (generated), the cycle
// counter and the control word, plus the read multiplexer. Reads are
// combinational from bus_addr; writes take effect at the clock edge.
module pmon3
    import pmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int NPRG = 2;

    logic             run, div, clr_prg, clr_cyc;
    logic [SEL_W-1:0] sel [NPRG];
    logic [BUS_W-1:0] prg_cnt [NPRG];
    logic [NPRG-1:0]  prg_ovf;
    logic [NPRG-1:0]  prg_wr;
    logic [BUS_W-1:0] cyc_cnt, ctrl_rd;
    logic             cyc_ovf, wr_ctrl, wr_cyc;

    // Write decode by register address.
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
        prg_wr[0] = bus_wr && (bus_addr == RA_CTR0);
        prg_wr[1] = bus_wr && (bus_addr == RA_CTR1);
        wr_cyc    = bus_wr && (bus_addr == RA_CYC);
    end

    pmon_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(bus_wdata),
        .ovf_set({cyc_ovf, prg_ovf[1], prg_ovf[0]}),
        .run(run), .div(div), .clr_prg(clr_prg), .clr_cyc(clr_cyc),
        .sel0(sel[0]), .sel1(sel[1]), .rd(ctrl_rd), .irq(irq)
    );

    for (genvar i = 0; i < NPRG; i++) begin : g_prg
        pmon_evt_ctr #(.CNT_W(BUS_W), .SEL_W(SEL_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .run(run), .sel(sel[i]), .evt(evt_in),
            .clr(clr_prg), .wr(prg_wr[i]), .wdata(bus_wdata),
            .cnt(prg_cnt[i]), .ovf(prg_ovf[i])
        );
    end

    pmon_cyc_ctr #(.CNT_W(BUS_W), .PRESC_W(PRESC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .clr(clr_cyc),
        .wr(wr_cyc), .wdata(bus_wdata), .cnt(cyc_cnt), .ovf(cyc_ovf)
    );

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            RA_CTRL: bus_rdata = ctrl_rd;
            RA_CTR0: bus_rdata = prg_cnt[0];
            RA_CTR1: bus_rdata = prg_cnt[1];
            default: bus_rdata = cyc_cnt;
        endcase
    end
endmodule

// File: tb/pmon3_bench.sv
module pmon3_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] evt = '0;
    logic         irq;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pmon3 u_pmon3 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt), .irq(irq));

    // Entries: sel0, sel1, pulsed line a, pulsed line b, cycles.
    localparam logic [39:0] VEC [6] = '{
        {8'h05, 8'h07, 8'h05, 8'h07, 8'd10},
        {8'h05, 8'h07, 8'h05, 8'h09, 8'd4},
        {8'h20, 8'h03, 8'h03, 8'h11, 8'd6},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'd3},
        {8'h09, 8'h09, 8'h09, 8'h01, 8'd7},
        {8'h20, 8'h20, 8'h01, 8'h02, 8'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(input bit run, input logic [7:0] s0, input logic [7:0] s1,
                                        input logic [10:0] low);
        return {4'h0, s0, s1, 1'b0, low} | {31'd0, run};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R10: reset state of every register and irq
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], r); check("R10 reset read", r, 32'd0);
        end
        check("R10 reset irq", {31'd0, irq}, 32'd0);

        // R5: arbitrary write and readback
        bus_write(2'd1, 32'hA5A51234);
        bus_write(2'd2, 32'h13572468);
        bus_write(2'd3, 32'hDEADBEEF);
        bus_read(2'd1, r); check("R5 ctr0 readback", r, 32'hA5A51234);
        bus_read(2'd2, r); check("R5 ctr1 readback", r, 32'h13572468);
        bus_read(2'd3, r); check("R5 cyc readback", r, 32'hDEADBEEF);

        // R10: select fields read back at their positions
        bus_write(2'd0, ctl(0, 8'hAB, 8'hCD, 11'd0));
        bus_read(2'd0, r); check("R10 ctrl select readback", r, 32'h0ABCD000);

        // R1: run bit low freezes everything
        bus_write(2'd0, ctl(0, 8'h05, 8'h05, 11'd0));
        evt = '1; step(10); evt = '0;
        bus_read(2'd1, r); check("R1 ctr0 frozen", r, 32'hA5A51234);
        bus_read(2'd2, r); check("R1 ctr1 frozen", r, 32'h13572468);
        bus_read(2'd3, r); check("R1 cyc frozen", r, 32'hDEADBEEF);

        // R4: reset bits, group separation, read as zero
        bus_write(2'd0, 32'h2);
        bus_read(2'd0, r); check("R4 reset bits read zero", r, 32'd0);
        bus_read(2'd1, r); check("R4 ctr0 cleared", r, 32'd0);
        bus_read(2'd2, r); check("R4 ctr1 cleared", r, 32'd0);
        bus_read(2'd3, r); check("R4 cyc untouched", r, 32'hDEADBEEF);
        bus_write(2'd0, 32'h4);
        bus_read(2'd3, r); check("R4 cyc cleared", r, 32'd0);

        // R2 / R3 / R9: table of selections and event patterns
        foreach (VEC[i]) begin
            logic [7:0] s0, s1, pa, pb, n;
            {s0, s1, pa, pb, n} = VEC[i];
            bus_write(2'd0, 32'h6);
            bus_write(2'd0, ctl(1, s0, s1, 11'd0));
            evt = '0; evt[pa] = 1'b1; evt[pb] = 1'b1;
            step(int'(n));
            evt = '0;
            bus_write(2'd0, ctl(0, s0, s1, 11'd0));
            bus_read(2'd1, r);
            check("R2 R3 ctr0 table", r, (s0 == pa || s0 == pb) ? {24'd0, n} : 32'd0);
            bus_read(2'd2, r);
            check("R2 R3 ctr1 table", r, (s1 == pa || s1 == pb) ? {24'd0, n} : 32'd0);
            bus_read(2'd3, r);
            check("R9 cyc table", r, {24'd0, n} + 32'd1);
        end

        // R5 R6 R8: counter 0 wraps, flag and interrupt
        bus_write(2'd1, 32'hFFFFFFFE);
        bus_write(2'd0, ctl(1, 8'h05, 8'h20, 11'h010));
        evt[5] = 1'b1; step(2); evt = '0;
        bus_write(2'd0, ctl(1, 8'h05, 8'h20, 11'h010));
        bus_read(2'd1, r); check("R5 wrap to zero", r, 32'd0);
        bus_read(2'd0, r); check("R6 flag0 set only", r & 32'h700, 32'h100);
        check("R8 irq raised", {31'd0, irq}, 32'd1);

        // R7: writing zero keeps flag, writing one clears it
        bus_write(2'd0, ctl(1, 8'h05, 8'h20, 11'h010));
        bus_read(2'd0, r); check("R7 zero write keeps flag", r & 32'h100, 32'h100);
        bus_write(2'd0, ctl(1, 8'h05, 8'h20, 11'h110));
        step(1);
        bus_read(2'd0, r); check("R7 one write clears flag", r & 32'h100, 32'd0);
        check("R8 irq dropped", {31'd0, irq}, 32'd0);

        // R7: wrap and clearing write in the same cycle, set wins
        bus_write(2'd1, 32'hFFFFFFFF);
        evt[5] = 1'b1;
        bus_write(2'd0, ctl(1, 8'h05, 8'h20, 11'h110));
        evt = '0;
        bus_read(2'd1, r); check("R7 collide counter", r, 32'd0);
        bus_read(2'd0, r); check("R7 set beats clear", r & 32'h100, 32'h100);
        bus_write(2'd0, ctl(0, 8'h20, 8'h20, 11'h100));
        step(2);

        // R8: flag without enable keeps irq low; enabling raises it
        bus_write(2'd2, 32'hFFFFFFFF);
        bus_write(2'd0, ctl(1, 8'h20, 8'h07, 11'd0));
        evt[7] = 1'b1; step(1); evt = '0;
        step(3);
        bus_read(2'd0, r); check("R6 flag1 set", r & 32'h700, 32'h200);
        check("R8 masked irq low", {31'd0, irq}, 32'd0);
        bus_write(2'd0, ctl(1, 8'h20, 8'h07, 11'h020));
        step(1);
        check("R8 enable raises irq", {31'd0, irq}, 32'd1);
        bus_write(2'd0, 32'h200);
        step(2);
        check("R8 irq clear after W1C", {31'd0, irq}, 32'd0);

        // R6 R9: cycle counter wrap, last enabled edge counted
        bus_write(2'd3, 32'hFFFFFFFD);
        bus_write(2'd0, 32'h41);
        step(3);
        bus_write(2'd0, 32'h40);
        bus_read(2'd3, r); check("R9 cyc wrap count", r, 32'd1);
        bus_read(2'd0, r); check("R6 cyc flag", r, 32'h440);
        check("R8 cyc irq", {31'd0, irq}, 32'd1);
        bus_write(2'd0, 32'h400);
        step(2);

        // R9: divide-by-64 mode
        bus_write(2'd0, 32'hD);
        step(128);
        bus_read(2'd0, r); check("R9 div ctrl readback", r, 32'h9);
        bus_write(2'd0, 32'h0);
        bus_read(2'd3, r); check("R9 divided count", r, 32'd2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule